// File: doc/BRIEF.md
# Stereo Polyphase FIR Convolution Sequencer

This block computes one stereo output sample of an asynchronous sample rate converter each time an output-sample strobe arrives. On the strobe it captures a starting address into the stereo sample memory, a starting coefficient pointer and a per-tap step. It then walks the taps of the filter for the left channel and repeats the walk for the right channel with the same start values. All products go through one shared multiplier and one accumulator.

The coefficient pointer is a 26-bit accumulator. Its 6 upper bits select the tap and its 20 lower bits hold the fractional phase. It advances by the step on every tap, and a walk ends when the next advance would carry out of the 26 bits. The filter therefore has 64 taps at a step of 2^20. When the input rate is above the output rate, the step is smaller than 2^20 and the filter becomes proportionally longer. Both memories are synchronous: data for an address appears in the cycle after the address is presented.

The finished pair of results is offered on a valid/ready output. `res_valid` rises together with a one-cycle `done` pulse. It stays high, with both results frozen, until the cycle in which `res_ready` is also high. A new strobe is only taken once that result has been accepted and the block has returned to idle.

Top module: `fir_seq_top`

## Requirements
- R1: A strobe seen while idle starts a convolution. In the next cycle `mem_rd` is 1, `mem_chan` is 0 (left), `ram_addr` equals the captured `ram_start`, and `rom_addr` equals bits [25:16] of the captured `rom_start`.
- R2: Within one channel, each successive tap presents `ram_addr` one lower than the previous tap, wrapping modulo 1024.
- R3: The coefficient pointer of tap j of a channel is start + j*step_eff (26 bits), and `rom_addr` shows its bits [25:16].
- R4: step_eff is the `step` input captured at the strobe, limited to at most 2^20 and at least 2^17.
- R5: Each channel runs N = ceil((2^26 - start) / step_eff) taps, that is, every pointer value below 2^26. N is 64 for step 2^20 and a start below 2^20.
- R6: All N left taps (`mem_chan`=0) are issued first, then all N right taps (`mem_chan`=1) from the same start address and pointer. `mem_rd` is high for exactly 2N cycles.
- R7: Each result is the signed sum over the taps of sample × coefficient (both signed 16-bit). The sum is rounded half-up at bit 15 (add 2^14, shift right by 15) and saturated to the range -32768..32767.
- R8: `done` is a single-cycle pulse. `done` and `res_valid` rise in the cycle 2N+1 clock edges after the edge that took the strobe.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_left` and `res_right` hold. A clock edge with both high takes the result and clears `res_valid`.
- R10: A strobe is ignored while taps are running and while a result is waiting to be taken. An ignored strobe causes no extra `done` and no extra memory reads, and it does not change the result in progress.
- R11: After reset, `res_valid`, `done`, `mem_rd`, `mem_chan`, `ram_addr` and `rom_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Output-sample strobe, starts a convolution when idle |
| ram_start | input | 10 | Sample memory start address, captured at the strobe |
| rom_start | input | 26 | Coefficient pointer start value, captured at the strobe |
| step | input | 21 | Pointer step per tap, captured at the strobe and clamped |
| ram_addr | output | 10 | Sample memory read address |
| mem_chan | output | 1 | Channel of the current tap (0 left, 1 right), sample memory bank select |
| rom_addr | output | 10 | Coefficient memory read address (pointer bits [25:16]) |
| mem_rd | output | 1 | A tap read is presented this cycle |
| ram_data | input | 16 | Signed sample, one cycle after the address |
| rom_data | input | 16 | Signed coefficient, one cycle after the address |
| res_valid | output | 1 | Result pair is available |
| res_ready | input | 1 | Consumer takes the result pair |
| res_left | output | 16 | Rounded left result |
| res_right | output | 16 | Rounded right result |
| done | output | 1 | One-cycle pulse when the right channel finishes |

## Verification
A corrupted address pointer or step register shows at the memory ports in the very next `mem_rd` cycle, as an address off the expected decrement or pointer track. A wrong channel flag shows on `mem_chan` at the left/right switch. A wrong rollover or tap counter shows later, as a wrong cycle count between the strobe and `done`. An accumulator or rounding error stays hidden until the result pair appears, 2N+1 cycles after the strobe, so each run compares both results bit-exactly against a model of the sum.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  // tag that travels with each tap read through the data pipeline
  typedef struct packed {
    logic vld;
    logic chan;
    logic first;
    logic last;
  } tap_tag_t;

endpackage

// File: rtl/fir_seq_step_clamp.sv
module fir_seq_step_clamp #(
  parameter int FRAC_W    = 20,
  parameter int MAX_DECIM = 8
) (
  input  logic [FRAC_W:0] step_in,
  output logic [FRAC_W:0] step_out
);
  localparam int DEC_SH = $clog2(MAX_DECIM);
  localparam logic [FRAC_W:0] STEP_ONE = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [FRAC_W:0] STEP_MIN = STEP_ONE >> DEC_SH;

  generate
    if (DEC_SH == 0) begin : g_unity
      // no decimation allowed: step is always unity
      assign step_out = STEP_ONE;
    end else begin : g_range
      always_comb begin
        if (step_in > STEP_ONE)      step_out = STEP_ONE;
        else if (step_in < STEP_MIN) step_out = STEP_MIN;
        else                         step_out = step_in;
      end
    end
  endgenerate
endmodule

// File: rtl/fir_seq_ctrl.sv
module fir_seq_ctrl
  import fir_seq_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int PTR_W  = 26,
  parameter int STEP_W = 21,
  parameter int ROM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              drained,
  input  logic [RAM_AW-1:0] ram_start,
  input  logic [PTR_W-1:0]  rom_start,
  input  logic [STEP_W-1:0] step_eff,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              chan,
  output logic              accept,
  output tap_tag_t          tag
);
  localparam int PAD_W = PTR_W + 1 - STEP_W;

  seq_state_e        state_q;
  logic              chan_q;
  logic              first_q;
  logic [RAM_AW-1:0] ram_q;
  logic [RAM_AW-1:0] ram_base_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_base_q;
  logic [STEP_W-1:0] step_q;
  logic [PTR_W-1:0]  ptr_nxt;
  logic              carry;

  // next pointer and rollover of the coefficient phase accumulator
  assign {carry, ptr_nxt} = {1'b0, ptr_q} + {{PAD_W{1'b0}}, step_q};

  assign accept   = strobe && (state_q == SEQ_IDLE);
  assign ram_addr = ram_q;
  assign rom_addr = ptr_q[PTR_W-1 -: ROM_AW];
  assign chan     = chan_q;

  always_comb begin
    tag.vld   = (state_q == SEQ_RUN);
    tag.chan  = chan_q;
    tag.first = first_q;
    tag.last  = carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      chan_q     <= 1'b0;
      first_q    <= 1'b0;
      ram_q      <= '0;
      ram_base_q <= '0;
      ptr_q      <= '0;
      ptr_base_q <= '0;
      step_q     <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (strobe) begin
            state_q    <= SEQ_RUN;
            chan_q     <= 1'b0;
            first_q    <= 1'b1;
            ram_q      <= ram_start;
            ram_base_q <= ram_start;
            ptr_q      <= rom_start;
            ptr_base_q <= rom_start;
            step_q     <= step_eff;
          end
        end
        SEQ_RUN: begin
          first_q <= 1'b0;
          if (carry) begin
            if (!chan_q) begin
              // left walk complete: restart the same walk for the right channel
              chan_q  <= 1'b1;
              first_q <= 1'b1;
              ram_q   <= ram_base_q;
              ptr_q   <= ptr_base_q;
            end else begin
              state_q <= SEQ_WAIT;
            end
          end else begin
            ram_q <= ram_q - 1'b1;
            ptr_q <= ptr_nxt;
          end
        end
        SEQ_WAIT: begin
          if (drained) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fir_seq_mac.sv
module fir_seq_mac
  import fir_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 42
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tap_tag_t                tag_in,
  input  logic [DATA_W-1:0]       ram_data,
  input  logic [COEF_W-1:0]       rom_data,
  output logic                    fin_vld,
  output logic                    fin_chan,
  output logic signed [ACC_W-1:0] fin_sum,
  output logic                    busy
);
  localparam int PROD_W = DATA_W + COEF_W;

  tap_tag_t                  tag_q;
  logic signed [ACC_W-1:0]   acc_q;
  logic signed [PROD_W-1:0]  prod;
  logic signed [ACC_W-1:0]   prod_ext;
  logic signed [ACC_W-1:0]   base;
  logic signed [ACC_W-1:0]   sum;

  // the tag is delayed one cycle so it lines up with the memory data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_in;
  end

  assign prod     = $signed(ram_data) * $signed(rom_data);
  assign prod_ext = ACC_W'(prod);
  assign base     = tag_q.first ? '0 : acc_q;
  assign sum      = base + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (tag_q.vld) acc_q <= sum;
  end

  assign fin_vld  = tag_q.vld && tag_q.last;
  assign fin_chan = tag_q.chan;
  assign fin_sum  = sum;
  assign busy     = tag_q.vld;
endmodule

// File: rtl/fir_seq_out.sv
module fir_seq_out #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 42
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fin_vld,
  input  logic                    fin_chan,
  input  logic signed [ACC_W-1:0] fin_sum,
  input  logic                    res_ready,
  output logic                    res_valid,
  output logic [DATA_W-1:0]       res_left,
  output logic [DATA_W-1:0]       res_right,
  output logic                    done
);
  localparam int SHIFT = COEF_W - 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

  logic signed [ACC_W-1:0] shifted;
  logic [DATA_W-1:0]       rnd;

  // round half-up at the product binary point, then saturate
  assign shifted = (fin_sum + HALF) >>> SHIFT;

  always_comb begin
    if (shifted > MAXV)      rnd = MAXV[DATA_W-1:0];
    else if (shifted < MINV) rnd = MINV[DATA_W-1:0];
    else                     rnd = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_left  <= '0;
      res_right <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (fin_vld) begin
        if (!fin_chan) begin
          res_left <= rnd;
        end else begin
          res_right <= rnd;
          res_valid <= 1'b1;
          done      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fir_seq_top.sv
module fir_seq_top
  import fir_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int RAM_AW    = 10,
  parameter int IDX_W     = 6,
  parameter int FRAC_W    = 20,
  parameter int ROM_AW    = 10,
  parameter int MAX_DECIM = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe,
  input  logic [RAM_AW-1:0]      ram_start,
  input  logic [IDX_W+FRAC_W-1:0] rom_start,
  input  logic [FRAC_W:0]        step,
  output logic [RAM_AW-1:0]      ram_addr,
  output logic                   mem_chan,
  output logic [ROM_AW-1:0]      rom_addr,
  output logic                   mem_rd,
  input  logic [DATA_W-1:0]      ram_data,
  input  logic [COEF_W-1:0]      rom_data,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [DATA_W-1:0]      res_left,
  output logic [DATA_W-1:0]      res_right,
  output logic                   done
);
  localparam int PTR_W    = IDX_W + FRAC_W;
  localparam int STEP_W   = FRAC_W + 1;
  localparam int MAX_TAPS = (1 << IDX_W) * MAX_DECIM;
  localparam int TAP_BITS = $clog2(MAX_TAPS);
  localparam int ACC_W    = DATA_W + COEF_W + TAP_BITS + 1;

  logic [STEP_W-1:0]       step_eff;
  logic                    accept;
  logic                    drained;
  tap_tag_t                tag;
  logic                    fin_vld;
  logic                    fin_chan;
  logic signed [ACC_W-1:0] fin_sum;
  logic                    mac_busy;

  fir_seq_step_clamp #(
    .FRAC_W    (FRAC_W),
    .MAX_DECIM (MAX_DECIM)
  ) i_clamp (
    .step_in  (step),
    .step_out (step_eff)
  );

  fir_seq_ctrl #(
    .RAM_AW (RAM_AW),
    .PTR_W  (PTR_W),
    .STEP_W (STEP_W),
    .ROM_AW (ROM_AW)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .drained   (drained),
    .ram_start (ram_start),
    .rom_start (rom_start),
    .step_eff  (step_eff),
    .ram_addr  (ram_addr),
    .rom_addr  (rom_addr),
    .chan      (mem_chan),
    .accept    (accept),
    .tag       (tag)
  );

  fir_seq_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W)
  ) i_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .tag_in   (tag),
    .ram_data (ram_data),
    .rom_data (rom_data),
    .fin_vld  (fin_vld),
    .fin_chan (fin_chan),
    .fin_sum  (fin_sum),
    .busy     (mac_busy)
  );

  fir_seq_out #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W)
  ) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_vld   (fin_vld),
    .fin_chan  (fin_chan),
    .fin_sum   (fin_sum),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_left  (res_left),
    .res_right (res_right),
    .done      (done)
  );

  assign mem_rd  = tag.vld;
  assign drained = !mac_busy && !res_valid;
endmodule

// File: rtl/fir_seq_sva.sv
module fir_seq_sva #(
  parameter int DATA_W = 16,
  parameter int RAM_AW = 10,
  parameter int ROM_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic [RAM_AW-1:0] ram_start,
  input logic [ROM_AW-1:0] rom_top,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              mem_chan,
  input logic              mem_rd,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_left,
  input logic [DATA_W-1:0] res_right,
  input logic              done
);
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_rd && !mem_chan && ram_addr == $past(ram_start) && rom_addr == $past(rom_top)));

  a_r2_ram_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && mem_chan == $past(mem_chan)) |-> ram_addr == $past(ram_addr) - 1'b1);

  a_r3_rom_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && mem_chan == $past(mem_chan)) |-> rom_addr >= $past(rom_addr));

  a_r6_left_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd) && mem_chan != $past(mem_chan)) |-> mem_chan);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_left) && $stable(res_right)));

  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!res_valid && !mem_rd));
endmodule

bind fir_seq_top fir_seq_sva #(
  .DATA_W (DATA_W),
  .RAM_AW (RAM_AW),
  .ROM_AW (ROM_AW)
) i_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .ram_start (ram_start),
  .rom_top   (rom_start[IDX_W+FRAC_W-1 -: ROM_AW]),
  .ram_addr  (ram_addr),
  .rom_addr  (rom_addr),
  .mem_chan  (mem_chan),
  .mem_rd    (mem_rd),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_left  (res_left),
  .res_right (res_right),
  .done      (done)
);

// File: tb/test_fir_seq_top.sv
module test_fir_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [9:0]  ram_start = '0;
  logic [25:0] rom_start = '0;
  logic [20:0] step = '0;
  logic [9:0]  ram_addr;
  logic        mem_chan;
  logic [9:0]  rom_addr;
  logic        mem_rd;
  logic [15:0] ram_data = '0;
  logic [15:0] rom_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_left;
  logic [15:0] res_right;
  logic        done;

  logic signed [15:0] ram_mem [0:2047];
  logic signed [15:0] rom_mem [0:1023];

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fir_seq_top i_fir_seq_top (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ram_start(ram_start),
    .rom_start(rom_start), .step(step), .ram_addr(ram_addr), .mem_chan(mem_chan),
    .rom_addr(rom_addr), .mem_rd(mem_rd), .ram_data(ram_data), .rom_data(rom_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_left(res_left),
    .res_right(res_right), .done(done)
  );

  // synchronous memory models: data one cycle after address
  always @(posedge clk) begin
    ram_data <= ram_mem[{mem_chan, ram_addr}];
    rom_data <= rom_mem[rom_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic longint clamp_step(input longint s);
    if (s > 64'd1048576) return 64'd1048576;
    if (s < 64'd131072)  return 64'd131072;
    return s;
  endfunction

  function automatic int tap_count(input longint start, input longint st);
    return int'(((64'd67108864 - start) + st - 1) / st);
  endfunction

  function automatic longint conv_sum(input int ch, input int rs, input longint start,
                                      input longint st, input int n);
    longint s = 0;
    for (int j = 0; j < n; j++) begin
      int a = (rs - j) & 1023;
      int idx = int'((start + longint'(j) * st) >> 16);
      s += longint'(ram_mem[ch * 1024 + a]) * longint'(rom_mem[idx]);
    end
    return s;
  endfunction

  function automatic longint rnd_sat(input longint s);
    longint r = (s + 64'sd16384) >>> 15;
    if (r > 32767)  return 32767;
    if (r < -32768) return -32768;
    return r;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 2048; i++) ram_mem[i] = 16'($signed(12'($urandom)));
    for (int i = 0; i < 1024; i++) rom_mem[i] = 16'($signed(12'($urandom)));
  endtask

  task automatic run_case(input int rs, input longint start, input longint step_raw,
                          input int hold, input bit inject, input bit pend);
    longint st = clamp_step(step_raw);
    int n = tap_count(start, st);
    longint exp_l = rnd_sat(conv_sum(0, rs, start, st, n));
    longint exp_r = rnd_sat(conv_sum(1, rs, start, st, n));
    int cnt = 0;
    int rd_n = 0;
    int bad_ram = 0;
    int bad_rom = 0;
    int bad_chan = 0;
    int extra = 0;
    bit got = 0;

    @(negedge clk);
    ram_start = rs[9:0];
    rom_start = start[25:0];
    step = step_raw[20:0];
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    while (!got && cnt < 4000) begin
      cnt++;
      if (mem_rd) begin
        int k = cnt - 1;
        int ch = (k >= n) ? 1 : 0;
        int j = ch ? k - n : k;
        longint ptr = start + longint'(j) * st;
        rd_n++;
        if (mem_chan != ch[0]) bad_chan++;
        if (ram_addr != 10'((rs - j) & 1023)) bad_ram++;
        if (rom_addr != 10'(ptr >> 16)) bad_rom++;
      end
      if (done) got = 1;
      else begin
        if (inject && cnt == 3) begin strobe = 1'b1; ram_start = ~ram_start; end
        if (inject && cnt == 4) strobe = 1'b0;
        @(negedge clk);
      end
    end
    chk(got, "R8", "done seen", got, 1);
    chk(cnt == 2 * n + 2, "R8", "strobe-to-done latency", cnt, 2 * n + 2);
    chk(rd_n == 2 * n, "R5", "tap reads", rd_n, 2 * n);
    chk(bad_chan == 0, "R6", "channel order mismatches", bad_chan, 0);
    chk(bad_ram == 0, "R2", "sample address mismatches", bad_ram, 0);
    chk(bad_rom == 0, "R3", "coefficient address mismatches", bad_rom, 0);
    chk(res_valid, "R8", "valid with done", res_valid, 1);
    chk(longint'($signed(res_left)) == exp_l, "R7", "left result", $signed(res_left), exp_l);
    chk(longint'($signed(res_right)) == exp_r, "R7", "right result", $signed(res_right), exp_r);
    @(negedge clk);
    chk(!done, "R8", "done single pulse", done, 0);
    for (int h = 0; h < hold; h++) begin
      if (pend && h == 0) strobe = 1'b1;
      if (pend && h == 1) strobe = 1'b0;
      @(negedge clk);
    end
    strobe = 1'b0;
    chk(res_valid && longint'($signed(res_left)) == exp_l && longint'($signed(res_right)) == exp_r,
        "R9", "held result", $signed(res_left), exp_l);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R9", "valid after handshake", res_valid, 0);
    if (inject || pend) begin
      for (int w = 0; w < 20; w++) begin
        if (mem_rd || done || res_valid) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R10", "activity after ignored strobe", extra, 0);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    fill_random();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!res_valid && !done && !mem_rd, "R11", "flags in reset", {res_valid, done, mem_rd}, 0);
    chk(ram_addr == 0 && rom_addr == 0 && !mem_chan, "R11", "addresses in reset",
        {mem_chan, ram_addr, rom_addr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!res_valid && !mem_rd, "R11", "idle after reset", {res_valid, mem_rd}, 0);

    // R1 R5: unity step from zero phase, 64 taps
    run_case(700, 0, 64'd1048576, 2, 1'b0, 1'b0);
    // R2: sample address wraps below zero
    run_case(3, 64'd1048575, 64'd1048576, 0, 1'b0, 1'b0);
    // R4: step above unity clamps to 2^20
    run_case(100, 64'd5000, 64'd2097151, 1, 1'b0, 1'b0);
    // R4: tiny step clamps to 2^17, 512 taps
    run_case(900, 64'd777, 64'd1000, 0, 1'b0, 1'b0);
    // R10: strobe during running taps and while result waits
    run_case(50, 64'd12345, 64'd700000, 4, 1'b1, 1'b0);
    run_case(60, 64'd999, 64'd1048576, 4, 1'b0, 1'b1);

    // R7: rounding half-up with a single tap near rollover
    ram_mem[5] = 16'sd1;
    ram_mem[1024 + 5] = -16'sd1;
    rom_mem[1023] = 16'sd16384;
    run_case(5, 64'd67108859, 64'd1048576, 0, 1'b0, 1'b0);

    // R7: positive and negative saturation
    for (int i = 0; i < 1024; i++) begin
      ram_mem[i] = 16'sd32767;
      ram_mem[1024 + i] = -16'sd32768;
      rom_mem[i] = 16'sd32767;
    end
    run_case(400, 0, 64'd1048576, 1, 1'b0, 1'b0);

    // random mix
    fill_random();
    for (int r = 0; r < 10; r++) begin
      int rs = int'($urandom_range(0, 1023));
      longint start = (r % 4 == 3) ? longint'($urandom_range(0, 67108863))
                                   : longint'($urandom_range(0, 1048575));
      longint st = longint'($urandom_range(131072, 1048576));
      int hold = int'($urandom_range(0, 3));
      run_case(rs, start, st, hold, 1'b0, 1'b0);
    end

    finish_run();
  end
endmodule